// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is a purely combinational integer arithmetic and logic unit together with its local operation decoder. The main instruction control hands it a two-bit operation class; for register-to-register instructions it also sees the six-bit function field. The local decoder turns these into a four-bit operation code. That code selects one of seven operations: add, subtract, signed set-on-less-than, AND, OR, XOR or NOR. The unit then produces a result word, a zero flag and a signed overflow flag.

Memory address calculation uses the add-only class, and equality branches use the subtract-only class. Both ignore the function field. The zero flag after a subtract tells an equality branch whether to be taken. The decoded operation code is a port of the block, so neighbouring logic and the bench can observe it.

Top module: `alu_twolevel`

## Requirements
- R1: With class 00 the operation code is 0110 (add) and the result is srcA+srcB modulo 2^WIDTH, whatever the function field holds.
- R2: With class 01 the operation code is 1110 (subtract) and the result is srcA-srcB modulo 2^WIDTH, whatever the function field holds.
- R3: With class 10 the function field decodes as follows: 100000→0110 add, 100010→1110 subtract, 100100→0000 AND, 100101→0001 OR, 100110→0010 XOR, 100111→0011 NOR, 101010→1111 set-on-less-than.
- R4: With class 10, any function field value not listed in R3 yields operation code 0110 and an add.
- R5: Class 11 yields operation code 0110 and an add, whatever the function field holds.
- R6: Operation codes 0000, 0001, 0010 and 0011 give the bitwise AND, OR, XOR and NOR of srcA and srcB.
- R7: Bit 3 of the operation code selects subtraction; 0110 gives the wrapped sum and 1110 the wrapped difference.
- R8: Set-on-less-than compares the operands as two's-complement signed values. The result is 1 in bit 0 when srcA<srcB, otherwise 0, and all upper bits are 0. The comparison stays correct when the difference overflows.
- R9: The zero flag is 1 exactly when the result is all zeros. In particular, it is 1 after a subtract of equal operands.
- R10: For add and subtract, the overflow flag is 1 exactly when the signed result falls outside the two's-complement range of WIDTH bits.
- R11: The overflow flag is 0 for all four logical operations and for set-on-less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opClass | input | 2 | Operation class from the main control |
| funct | input | 6 | Function field of a register-to-register instruction |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| aluOp | output | 4 | Decoded operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds the block with its default width of 32 and function field width of 6. At that width the operand corners apply: the most negative and most positive values, all-ones, and equal operands. These cover both overflow directions of add and subtract, set-on-less-than across an overflowing difference, and the zero flag after a wrapped sum. Every function field code, including unlisted ones, is swept under all four classes. Pseudo-random operands fill in the common cases.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_XOR = 4'b0010,
    OP_NOR = 4'b0011,
    OP_ADD = 4'b0110,
    OP_SUB = 4'b1110,
    OP_SLT = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_RTYPE  = 2'b10,
    CLS_SPARE  = 2'b11
  } op_class_e;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic       negB;      // invert operand B and carry in one
    logic       unitLogic; // result from bitwise unit
    logic       unitArith; // result from adder
    logic       unitSlt;   // result from signed compare
    logic [1:0] logicFn;   // 00 and, 01 or, 10 xor, 11 nor
  } alu_strobes_t;
endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_pkg::*;
#(
  parameter int FUNCT_W = 6
) (
  input  logic [1:0]         opClass,
  input  logic [FUNCT_W-1:0] funct,
  output logic [3:0]         aluOp,
  output alu_strobes_t       strobes
);
  alu_op_e opSel;

  // first level: class; second level: function field
  always_comb begin
    unique case (op_class_e'(opClass))
      CLS_MEM:    opSel = OP_ADD;
      CLS_BRANCH: opSel = OP_SUB;
      CLS_RTYPE: begin
        case (funct)
          FN_ADD:  opSel = OP_ADD;
          FN_SUB:  opSel = OP_SUB;
          FN_AND:  opSel = OP_AND;
          FN_OR:   opSel = OP_OR;
          FN_XOR:  opSel = OP_XOR;
          FN_NOR:  opSel = OP_NOR;
          FN_SLT:  opSel = OP_SLT;
          default: opSel = OP_ADD;
        endcase
      end
      default:    opSel = OP_ADD;
    endcase
  end

  assign aluOp = opSel;

  // strobes are taken from the code bits, so the code alone steers the datapath
  always_comb begin
    strobes.negB      = aluOp[3];
    strobes.unitLogic = ~aluOp[2];
    strobes.unitArith = aluOp[2] & ~(aluOp[3] & aluOp[0]);
    strobes.unitSlt   = aluOp[3] & aluOp[2] & aluOp[0];
    strobes.logicFn   = aluOp[1:0];
  end

  always_comb begin
    if (opClass == 2'b00) begin
      AST_MEM_CLASS_ADD: assert (aluOp == 4'b0110); // R1
    end
    if (opClass == 2'b01) begin
      AST_BRANCH_CLASS_SUB: assert (aluOp == 4'b1110 && strobes.negB); // R2
    end
    AST_ONE_UNIT: assert ($onehot({strobes.unitLogic, strobes.unitArith, strobes.unitSlt})); // R3
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  alu_strobes_t     strobes,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bOp;
  logic [WIDTH:0]   sumExt;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] sltRes;
  logic             ovfRaw;
  logic             lessThan;

  assign bOp    = strobes.negB ? ~srcB : srcB;
  assign sumExt = {1'b0, srcA} + {1'b0, bOp} + {{WIDTH{1'b0}}, strobes.negB};
  assign sum    = sumExt[MSB:0];

  // signed overflow: operands agree in sign, sum disagrees
  assign ovfRaw   = (srcA[MSB] == bOp[MSB]) && (sum[MSB] != srcA[MSB]);
  assign lessThan = sum[MSB] ^ ovfRaw;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (strobes.logicFn)
        2'b00:   logicRes[i] = srcA[i] & srcB[i];
        2'b01:   logicRes[i] = srcA[i] | srcB[i];
        2'b10:   logicRes[i] = srcA[i] ^ srcB[i];
        default: logicRes[i] = ~(srcA[i] | srcB[i]);
      endcase
    end
  end

  assign sltRes = {{(WIDTH-1){1'b0}}, lessThan};

  always_comb begin
    result = '0;
    if (strobes.unitLogic) result = logicRes;
    if (strobes.unitArith) result = sum;
    if (strobes.unitSlt)   result = sltRes;
  end

  assign zero     = ~|result;
  assign overflow = ovfRaw & strobes.unitArith;

  always_comb begin
    if (strobes.unitSlt) begin
      AST_SLT_UPPER_CLEAR: assert (result[MSB:1] == '0); // R8
    end
    if (strobes.unitArith && strobes.negB && srcA == srcB) begin
      AST_EQUAL_SUB_ZERO: assert (zero); // R9
    end
    if (!strobes.unitArith) begin
      AST_NO_OVERFLOW: assert (!overflow); // R11
    end
    if (strobes.unitArith && !strobes.negB && srcA[MSB] != srcB[MSB]) begin
      AST_MIXED_ADD_NO_OVF: assert (!overflow); // R10
    end
  end
endmodule

// File: rtl/alu_twolevel.sv
module alu_twolevel
  import alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int FUNCT_W = 6
) (
  input  logic [1:0]         opClass,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [WIDTH-1:0]   srcA,
  input  logic [WIDTH-1:0]   srcB,
  output logic [3:0]         aluOp,
  output logic [WIDTH-1:0]   result,
  output logic               zero,
  output logic               overflow
);
  alu_strobes_t strobes;

  alu_ctrl_decode #(.FUNCT_W(FUNCT_W)) ctrl_i (
    .opClass (opClass),
    .funct   (funct),
    .aluOp   (aluOp),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .srcA     (srcA),
    .srcB     (srcB),
    .strobes  (strobes),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );
endmodule

// File: tb/alu_twolevel_tb_top.sv
`timescale 1ns/1ps
module alu_twolevel_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  opClass = '0;
  logic [5:0]  funct = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [3:0]  aluOp;
  logic [31:0] result;
  logic        zero, overflow;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  alu_twolevel dut_i (
    .opClass(opClass), .funct(funct), .srcA(srcA), .srcB(srcB),
    .aluOp(aluOp), .result(result), .zero(zero), .overflow(overflow)
  );

  // behavioural reference
  function automatic logic [3:0] refOp(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'd0) return 4'd6;
    if (c == 2'd1) return 4'd14;
    if (c == 2'd3) return 4'd6;
    case (f)
      6'd32: return 4'd6;
      6'd34: return 4'd14;
      6'd36: return 4'd0;
      6'd37: return 4'd1;
      6'd38: return 4'd2;
      6'd39: return 4'd3;
      6'd42: return 4'd15;
      default: return 4'd6;
    endcase
  endfunction

  task automatic refCalc(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic v);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint wide;
    v = 1'b0;
    case (op)
      4'd0:  r = a & b;
      4'd1:  r = a | b;
      4'd2:  r = a ^ b;
      4'd3:  r = ~(a | b);
      4'd14: begin
        wide = sa - sb;
        r = 32'(wide);
        v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      4'd15: r = (sa < sb) ? 32'd1 : 32'd0;
      default: begin
        wide = sa + sb;
        r = 32'(wide);
        v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
    endcase
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b);
    logic [3:0] eop; logic [31:0] er; logic ev;
    @(negedge clk);
    opClass = c; funct = f; srcA = a; srcB = b;
    eop = refOp(c, f);
    refCalc(eop, a, b, er, ev);
    @(posedge clk); #1;
    check(tag, "aluOp", {28'd0, aluOp}, {28'd0, eop});
    check(tag, "result", result, er);
    check({tag, "/R9"}, "zero", {31'd0, zero}, {31'd0, (er == 32'd0)});
    check(ev ? {tag, "/R10"} : {tag, "/R10/R11"}, "overflow", {31'd0, overflow}, {31'd0, ev});
  endtask

  localparam logic [31:0] MAXP = 32'h7fffffff;
  localparam logic [31:0] MINN = 32'h80000000;

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero inputs give add with zero result
    #1;
    check("R1", "reset aluOp", {28'd0, aluOp}, 32'd6);
    check("R9", "reset zero", {31'd0, zero}, 32'd1);

    // R1 class 00 ignores funct
    apply("R1", 2'd0, 6'd34, 32'd5, 32'd7);
    apply("R1", 2'd0, 6'd42, 32'hffffffff, 32'd1);
    // R2 class 01 ignores funct
    apply("R2", 2'd1, 6'd32, 32'd9, 32'd9);
    apply("R2", 2'd1, 6'd36, 32'd3, 32'd10);
    // R3 each function code
    apply("R3", 2'd2, 6'd32, 32'd100, 32'd23);
    apply("R3", 2'd2, 6'd34, 32'd100, 32'd23);
    apply("R3/R6", 2'd2, 6'd36, 32'hf0f0ff00, 32'h0ff0f0f0);
    apply("R3/R6", 2'd2, 6'd37, 32'hf0f0ff00, 32'h0ff0f0f0);
    apply("R3/R6", 2'd2, 6'd38, 32'hf0f0ff00, 32'h0ff0f0f0);
    apply("R3/R6", 2'd2, 6'd39, 32'hf0f0ff00, 32'h0ff0f0f0);
    apply("R3/R8", 2'd2, 6'd42, 32'hfffffffe, 32'd1);
    // R4 unlisted function codes
    apply("R4", 2'd2, 6'd0, 32'd11, 32'd22);
    apply("R4", 2'd2, 6'd35, 32'd11, 32'd22);
    // R5 class 11
    apply("R5", 2'd3, 6'd34, 32'd40, 32'd2);
    // R7 wrap, R10 overflow corners
    apply("R7/R10", 2'd0, 6'd0, MAXP, 32'd1);
    apply("R7/R10", 2'd0, 6'd0, MINN, MINN);
    apply("R7/R10", 2'd1, 6'd0, MINN, 32'd1);
    apply("R7/R10", 2'd1, 6'd0, MAXP, 32'hffffffff);
    apply("R7/R9", 2'd0, 6'd0, 32'hffffffff, 32'd1);
    // R8 slt across overflowing difference
    apply("R8", 2'd2, 6'd42, MINN, 32'd1);
    apply("R8", 2'd2, 6'd42, MAXP, 32'hffffffff);
    apply("R8", 2'd2, 6'd42, 32'd5, 32'd5);
    // R11 logic ops on extreme operands
    apply("R11", 2'd2, 6'd39, 32'd0, 32'd0);
    apply("R11", 2'd2, 6'd37, MAXP, MAXP);

    // sweep every funct under every class
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 64; f++)
        apply("R3/R4", 2'(c), 6'(f), $urandom, $urandom);
    // random mix with reused operands for equality cases
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = (k % 5 == 0) ? a : $urandom;
      apply("R6/R7/R8", 2'($urandom_range(0, 3)), (k % 2 == 0) ? 6'($urandom_range(32, 42)) : 6'($urandom), a, b);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule